// File: doc/BRIEF.md
# Fail-Safe Clock Monitor

This block watches a clock that comes from an external oscillator and reports when it stops. A free-running internal oscillator clocks the block. A divider on that oscillator makes a slow sample tick, one every 64 internal cycles by default. Each falling edge of the watched clock sets a monitor latch, and each sample tick clears it. If a whole sample period ends with the latch still clear, the watched clock has died. The block then raises a sticky fail flag and a one-cycle interrupt pulse, and it asserts a clock-select override that moves the device clock onto the internal oscillator.

The monitor works only while its enable input is high. While enabled, the block also asks for the internal oscillator to be kept running, whichever source is selected as the device clock. The first sample period after reset or after enable is only used to arm the check, so a watched clock that is still starting cannot raise a false alarm. Only reset clears a failure.

Top module: `fscm_monitor`

## Requirements
- R1: `intosc_hold` is high exactly while `fscm_en` is high, whatever the state of the watched clock.
- R2: Failures are judged only on sample ticks, which come every 64 `int_clk` cycles (parameter `DIV`) while enabled. With the watched clock stopped from the moment of enable, `fail_flag` is still 0 100 cycles after enable and is 1 by 135 cycles after enable.
- R3: If at least one falling edge of `mon_clk` arrives in every sample period, no failure is declared. This holds for watched clocks both faster and slower than `int_clk`, down to a period of about 40 `int_clk` cycles.
- R4: If a full sample period passes with no falling edge of `mon_clk`, a failure is declared. This covers a stopped clock and a clock whose period is longer than the sample period.
- R5: The first sample tick after reset or after `fscm_en` rises only arms the check and never declares a failure.
- R6: Once `fail_flag` is 1 it stays 1 until `rst_n` is asserted, even if `mon_clk` starts toggling again.
- R7: `fail_irq` is high for exactly one `int_clk` cycle, in the cycle where `fail_flag` first becomes 1. It does not pulse again while the flag stays set.
- R8: `clk_sel_int` (1 = device clock from the internal oscillator) is 1 whenever `fail_flag` is 1 and 0 otherwise.
- R9: While `fscm_en` is 0, no failure is declared, even with `mon_clk` stopped.
- R10: While `rst_n` is low (active-low, asynchronous), `fail_flag`, `fail_irq` and `clk_sel_int` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Watched clock from the external oscillator |
| int_clk | input | 1 | Free-running internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fscm_en | input | 1 | Monitor enable (configuration bit) |
| intosc_hold | output | 1 | Request to keep the internal oscillator running |
| fail_flag | output | 1 | Sticky clock-failure flag |
| fail_irq | output | 1 | One-cycle pulse when a failure is first detected |
| clk_sel_int | output | 1 | Override that selects the internal oscillator as device clock |

## Verification
Some properties are checked by the assertions on every internal-clock cycle. These are: the fail flag never falls once set, the interrupt pulse lasts one cycle and appears only as the flag rises, the flag rises only right after a sample tick, the override tracks the flag, and no failure appears while the monitor is disabled. Other behaviour needs a real watched clock with chosen periods, so only the bench scenarios can show it. That covers whether a healthy clock at various rates is left alone, whether a stopped or too-slow clock is caught, the exact window in which the first sample period is ignored, and stickiness after the watched clock restarts.

// File: rtl/fscm_pkg.sv
package fscm_pkg;

  // Next value of the sample divider counter; wraps at div-1.
  function automatic int unsigned fscm_next_count(input int unsigned cnt,
                                                  input int unsigned div);
    return (cnt >= div - 1) ? 0 : cnt + 1;
  endfunction

  // A failure is declared only on an armed tick with no monitored activity.
  function automatic logic fscm_is_failure(input logic armed,
                                           input logic seen);
    return armed & ~seen;
  endfunction

endpackage

// File: rtl/fscm_sample_div.sv
module fscm_sample_div #(
  parameter int unsigned DIV = 64
) (
  input  logic int_clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  import fscm_pkg::*;

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en & (cnt_q == LAST);

  always_ff @(posedge int_clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (!en) cnt_q <= '0;
    else          cnt_q <= CW'(fscm_next_count(int'(cnt_q), DIV));
  end
endmodule

// File: rtl/fscm_edge_latch.sv
module fscm_edge_latch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic int_clk,
  input  logic rst_n,
  input  logic clr,
  output logic seen
);
  localparam int unsigned NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic latch_q;
  logic latch_rst_n;
  logic [NS-1:0] sync_q;

  // Cleared asynchronously by the registered clear from the sample domain.
  assign latch_rst_n = rst_n & ~clr;

  always_ff @(negedge mon_clk or negedge latch_rst_n) begin
    if (!latch_rst_n) latch_q <= 1'b0;
    else              latch_q <= 1'b1;
  end

  always_ff @(posedge int_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[NS-2:0], latch_q};
  end

  assign seen = sync_q[NS-1];
endmodule

// File: rtl/fscm_judge.sv
module fscm_judge (
  input  logic int_clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic seen,
  output logic clr,
  output logic armed,
  output logic fail_flag,
  output logic fail_irq
);
  import fscm_pkg::*;

  logic fail_now;
  assign fail_now = en & tick & fscm_is_failure(armed, seen) & ~fail_flag;

  always_ff @(posedge int_clk or negedge rst_n) begin
    if (!rst_n) begin
      clr       <= 1'b0;
      armed     <= 1'b0;
      fail_flag <= 1'b0;
      fail_irq  <= 1'b0;
    end else begin
      clr      <= en & tick;
      fail_irq <= fail_now;
      if (fail_now) fail_flag <= 1'b1;
      if (!en)       armed <= 1'b0;
      else if (tick) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/fscm_monitor.sv
module fscm_monitor #(
  parameter int unsigned DIV         = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic int_clk,
  input  logic rst_n,
  input  logic fscm_en,
  output logic intosc_hold,
  output logic fail_flag,
  output logic fail_irq,
  output logic clk_sel_int
);
  // Named internal events, used by the bound checker.
  logic sample_tick;
  logic mon_seen;
  logic latch_clr;
  logic armed;

  fscm_sample_div #(.DIV(DIV)) u_div (
    .int_clk (int_clk),
    .rst_n   (rst_n),
    .en      (fscm_en),
    .tick    (sample_tick)
  );

  fscm_edge_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
    .mon_clk (mon_clk),
    .int_clk (int_clk),
    .rst_n   (rst_n),
    .clr     (latch_clr),
    .seen    (mon_seen)
  );

  fscm_judge u_judge (
    .int_clk   (int_clk),
    .rst_n     (rst_n),
    .en        (fscm_en),
    .tick      (sample_tick),
    .seen      (mon_seen),
    .clr       (latch_clr),
    .armed     (armed),
    .fail_flag (fail_flag),
    .fail_irq  (fail_irq)
  );

  assign intosc_hold = fscm_en;
  assign clk_sel_int = fail_flag;
endmodule

// File: rtl/fscm_monitor_chk.sv
module fscm_monitor_chk (
  input logic int_clk,
  input logic rst_n,
  input logic fscm_en,
  input logic sample_tick,
  input logic armed,
  input logic fail_flag,
  input logic fail_irq,
  input logic clk_sel_int
);
  AST_FLAG_STICKY: assert property (@(posedge int_clk) disable iff (!rst_n)
    fail_flag |=> fail_flag); // R6
  AST_IRQ_SINGLE: assert property (@(posedge int_clk) disable iff (!rst_n)
    fail_irq |=> !fail_irq); // R7
  AST_IRQ_ON_RISE: assert property (@(posedge int_clk) disable iff (!rst_n)
    fail_irq |-> $rose(fail_flag)); // R7
  AST_RISE_HAS_IRQ: assert property (@(posedge int_clk) disable iff (!rst_n)
    $rose(fail_flag) |-> fail_irq); // R7
  AST_FAIL_AFTER_TICK: assert property (@(posedge int_clk) disable iff (!rst_n)
    $rose(fail_flag) |-> ($past(sample_tick) && $past(armed))); // R2
  AST_TICK_SPACED: assert property (@(posedge int_clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick); // R2
  AST_SEL_TRACKS_FLAG: assert property (@(posedge int_clk) disable iff (!rst_n)
    fail_flag |-> clk_sel_int); // R8
  AST_NO_FAIL_DISABLED: assert property (@(posedge int_clk) disable iff (!rst_n)
    (!fscm_en && !fail_flag) |=> !fail_flag); // R9
  AST_FIRST_TICK_ARMS: assert property (@(posedge int_clk) disable iff (!rst_n)
    (sample_tick && !armed) |=> !$rose(fail_flag)); // R5
endmodule

bind fscm_monitor fscm_monitor_chk u_chk (
  .int_clk     (int_clk),
  .rst_n       (rst_n),
  .fscm_en     (fscm_en),
  .sample_tick (sample_tick),
  .armed       (armed),
  .fail_flag   (fail_flag),
  .fail_irq    (fail_irq),
  .clk_sel_int (clk_sel_int)
);

// File: tb/tb_fscm_monitor.sv
`timescale 1ns/1ps
module tb_fscm_monitor;
  logic mon_clk, int_clk, rst_n, fscm_en;
  logic intosc_hold, fail_flag, fail_irq, clk_sel_int;
  int   mon_half;
  int   n_checks, n_fails;
  bit   done;

  fscm_monitor dut (
    .mon_clk(mon_clk), .int_clk(int_clk), .rst_n(rst_n), .fscm_en(fscm_en),
    .intosc_hold(intosc_hold), .fail_flag(fail_flag), .fail_irq(fail_irq),
    .clk_sel_int(clk_sel_int)
  );

  initial int_clk = 1'b0;
  always #2.5 int_clk = ~int_clk;   // 200 MHz

  // Watched clock: half period in ns, 0 = stopped.
  initial begin
    mon_clk = 1'b1;
    forever begin
      if (mon_half == 0) #1;
      else begin #(mon_half) mon_clk = ~mon_clk; end
    end
  end

  // Vector table: mon half period, enable, expected fail.
  localparam int NV = 7;
  localparam int V_HALF [NV] = '{2,   7,   40,  100, 0,   400, 0};
  localparam bit V_EN   [NV] = '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0};
  localparam bit V_EXP  [NV] = '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0};

  task automatic check(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge int_clk);
    rst_n = 1'b1;
    @(negedge int_clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #900000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int irq_cnt;
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0; fscm_en = 1'b0; mon_half = 2;
    repeat (3) @(negedge int_clk);
    // R10: reset state
    check("R10 fail_flag in reset", fail_flag, 1'b0);
    check("R10 fail_irq in reset", fail_irq, 1'b0);
    check("R10 clk_sel_int in reset", clk_sel_int, 1'b0);

    // Table walk: R1, R3, R4, R8, R9
    for (int i = 0; i < NV; i++) begin
      fscm_en = 1'b0;
      mon_half = V_HALF[i];
      do_reset();
      fscm_en = V_EN[i];
      repeat (500) @(negedge int_clk);
      check($sformatf("R3/R4/R9 vec%0d fail_flag", i), fail_flag, V_EXP[i]);
      check($sformatf("R8 vec%0d clk_sel_int", i), clk_sel_int, V_EXP[i]);
      check($sformatf("R1 vec%0d intosc_hold", i), intosc_hold, V_EN[i]);
    end

    // R2, R5: first sample period ignored, failure at second tick
    fscm_en = 1'b0; mon_half = 0;
    do_reset();
    fscm_en = 1'b1;
    repeat (100) @(negedge int_clk);
    check("R5 no fail in first period", fail_flag, 1'b0);
    repeat (35) @(negedge int_clk);
    check("R2 fail by second tick", fail_flag, 1'b1);

    // R7, R6: healthy then stop, single irq pulse, sticky after restart
    fscm_en = 1'b0; mon_half = 2;
    do_reset();
    fscm_en = 1'b1;
    repeat (300) @(negedge int_clk);
    check("R3 healthy before stop", fail_flag, 1'b0);
    mon_half = 0;
    irq_cnt = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge int_clk);
      if (fail_irq) irq_cnt++;
    end
    check("R4 stop detected", fail_flag, 1'b1);
    check("R7 irq exactly one cycle", irq_cnt == 1, 1'b1);
    mon_half = 7;
    irq_cnt = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge int_clk);
      if (fail_irq) irq_cnt++;
    end
    check("R6 flag sticky after restart", fail_flag, 1'b1);
    check("R7 no repeat irq", irq_cnt == 0, 1'b1);

    // R9: enable dropped after a restart does not produce a failure
    fscm_en = 1'b0; mon_half = 0;
    do_reset();
    repeat (300) @(negedge int_clk);
    check("R9 disabled stopped clock", fail_flag, 1'b0);
    check("R1 hold low when disabled", intosc_hold, 1'b0);

    // R10: reset mid-failure clears outputs
    fscm_en = 1'b1;
    repeat (300) @(negedge int_clk);
    check("R4 failure before reset", fail_flag, 1'b1);
    rst_n = 1'b0;
    @(negedge int_clk);
    check("R10 flag cleared by reset", fail_flag, 1'b0);
    check("R10 sel cleared by reset", clk_sel_int, 1'b0);
    check("R10 irq low in reset", fail_irq, 1'b0);
    rst_n = 1'b1;
    fscm_en = 1'b0;
    repeat (5) @(negedge int_clk);
    finish_run();
  end
endmodule